// File: doc/BRIEF.md
# DSD Bitstream Validity Monitor

This block watches one-bit DSD audio streams, one per channel, and flags two fault patterns. A stream stuck at a constant level is reported as a static fault, and the block raises a per-channel mute request. A stream that is heavily one-sided over its most recent 28 bits is reported as an invalid fault, and the block raises a per-channel attenuate request. Every channel samples its data bit on the cycles where the shared bit-clock enable is high.

Each detector has its own enable bit, held in a small configuration register that software loads with a write strobe. After reset the static detector is on and the invalid detector is off. A bypass select sends the raw data bits straight to the converter output and switches off attenuation. A single combined output reports when any request on any channel is active, for use by external mute-pin logic. Filtering, volume control and mute-pin timing are outside this block.

Top module: `dsd_validity_monitor`

## Requirements
- R1: With the static detector enabled, a channel's `mute_req` bit is high whenever that channel's last 28 sampled bits are all 0 or all 1.
- R2: After reset the static enable reads as 1 and the invalid enable reads as 0, with no configuration write needed.
- R3: With the invalid detector enabled and bypass low, a channel's `atten_req` bit is high whenever 25 or more of its last 28 sampled bits share one value, that is, a ones count of at least 25 or at most 3.
- R4: The window advances by exactly one bit on each cycle where `bclk_en` is high, and the window does not change on any other cycle.
- R5: A request drops as soon as the current window no longer meets its condition. For a static fault this means the first differing bit clears it.
- R6: No request is raised until at least 28 bits have been sampled since reset.
- R7: While a detector's enable is 0, that detector's request stays low on every channel.
- R8: When `bypass` is high, `dac_bit` equals `dsd_bit` in the same cycle and `atten_req` is forced low. When `bypass` is low, `dac_bit` carries the most recently sampled bit, which is 0 before the first sample.
- R9: `mute_any` is high exactly when at least one `mute_req` or `atten_req` bit is high.
- R10: A clock edge with `cfg_we` high loads `cfg_static_d` and `cfg_invalid_d` into the two enables, and they take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_en | input | 1 | Bit-clock enable; sample all channels this cycle |
| dsd_bit | input | NCH | One data bit per channel |
| cfg_we | input | 1 | Write strobe for the enable register |
| cfg_static_d | input | 1 | New value for the static-detector enable |
| cfg_invalid_d | input | 1 | New value for the invalid-detector enable |
| bypass | input | 1 | Direct conversion select |
| dac_bit | output | NCH | Data bit toward the converter |
| mute_req | output | NCH | Per-channel static fault mute request |
| atten_req | output | NCH | Per-channel invalid fault attenuate request |
| mute_any | output | 1 | OR of all requests on all channels |

## Verification
Requests and the registered `dac_bit` change after the same clock edge that samples a bit, so each one is due in the cycle that follows. The bench updates its model on that edge and compares at the next falling edge. A configuration write is due one cycle after its strobe. The bypass path is combinational, so it is compared at the same falling edge while the inputs are still held. Inputs change only after each comparison, so every check sees a settled state.

// File: rtl/dsd_mon_pkg.sv
// Shared types for the DSD validity monitor.
package dsd_mon_pkg;
    // Detector enables held in the configuration register.
    typedef struct packed {
        logic static_en;
        logic invalid_en;
    } det_cfg_t;

    // Reset value: static detection on, invalid detection off.
    localparam det_cfg_t CFG_RESET = '{static_en: 1'b1, invalid_en: 1'b0};
endpackage

// File: rtl/dsd_win_track.sv
// Sliding bit-history window for one channel.
// Keeps the last WIN bits, a running ones count and a saturating fill count.
// Assumes the history resets to zero, so subtracting the outgoing bit is
// correct even before the window has filled.
module dsd_win_track #(
    parameter int WIN = 28,
    localparam int CW = $clog2(WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift,
    input  logic          din,
    output logic [CW-1:0] ones,
    output logic          full,
    output logic          seen_any,
    output logic          newest
);
    logic [WIN-1:0] hist;
    logic [CW-1:0]  fill;

    // Shift the new bit in and keep the ones count in step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
            ones <= '0;
        end else if (shift) begin
            hist <= {hist[WIN-2:0], din};
            ones <= ones + CW'(din) - CW'(hist[WIN-1]);
        end
    end

    // Count received bits up to the window length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill <= '0;
        else if (shift && fill != CW'(WIN))
            fill <= fill + 1'b1;
    end

    assign full     = (fill == CW'(WIN));
    assign seen_any = (fill != '0);
    assign newest   = hist[0];
endmodule

// File: rtl/dsd_run_len.sv
// Run-length counter for one channel.
// Counts identical consecutive bits, saturating at WIN and restarting
// at 1 on a change of level or on the first bit after reset.
module dsd_run_len #(
    parameter int WIN = 28,
    localparam int CW = $clog2(WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift,
    input  logic          din,
    input  logic          prev,
    input  logic          seen_any,
    output logic          stuck
);
    logic [CW-1:0] run;

    // Advance, saturate or restart the run on each sampled bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= '0;
        else if (shift) begin
            if (!seen_any || din != prev)
                run <= CW'(1);
            else if (run != CW'(WIN))
                run <= run + 1'b1;
        end
    end

    assign stuck = (run == CW'(WIN));
endmodule

// File: rtl/dsd_chan_judge.sv
// Per-channel fault decision.
// Combines the window and run tracking into gated mute and attenuate
// requests, and picks the converter bit for normal or bypass mode.
module dsd_chan_judge #(
    parameter int WIN    = 28,
    parameter int THRESH = 24,
    localparam int CW    = $clog2(WIN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift,
    input  logic din,
    input  logic static_en,
    input  logic invalid_en,
    input  logic bypass,
    output logic dac_bit,
    output logic mute_req,
    output logic atten_req
);
    logic [CW-1:0] ones;
    logic          full, seen_any, newest, stuck, skewed;

    dsd_win_track #(.WIN(WIN)) u_win (
        .clk(clk), .rst_n(rst_n), .shift(shift), .din(din),
        .ones(ones), .full(full), .seen_any(seen_any), .newest(newest)
    );

    dsd_run_len #(.WIN(WIN)) u_run (
        .clk(clk), .rst_n(rst_n), .shift(shift), .din(din),
        .prev(newest), .seen_any(seen_any), .stuck(stuck)
    );

    // Flag a window dominated by either level.
    always_comb begin
        skewed = full && ((ones > CW'(THRESH)) || (CW'(WIN) - ones > CW'(THRESH)));
    end

    assign mute_req  = static_en && stuck;
    assign atten_req = invalid_en && !bypass && skewed;
    assign dac_bit   = bypass ? din : newest;
endmodule

// File: rtl/dsd_validity_monitor.sv
// Top level: multi-channel DSD validity monitor.
// Holds the detector-enable register and instantiates one judge per
// channel. All channels share the bit-clock enable and configuration.
module dsd_validity_monitor #(
    parameter int NCH    = 2,
    parameter int WIN    = 28,
    parameter int THRESH = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bclk_en,
    input  logic [NCH-1:0] dsd_bit,
    input  logic           cfg_we,
    input  logic           cfg_static_d,
    input  logic           cfg_invalid_d,
    input  logic           bypass,
    output logic [NCH-1:0] dac_bit,
    output logic [NCH-1:0] mute_req,
    output logic [NCH-1:0] atten_req,
    output logic           mute_any
);
    import dsd_mon_pkg::*;

    det_cfg_t cfg_q;

    // Configuration register with its defaults applied on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= CFG_RESET;
        else if (cfg_we)
            cfg_q <= '{static_en: cfg_static_d, invalid_en: cfg_invalid_d};
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dsd_chan_judge #(.WIN(WIN), .THRESH(THRESH)) u_judge (
            .clk(clk), .rst_n(rst_n), .shift(bclk_en), .din(dsd_bit[c]),
            .static_en(cfg_q.static_en), .invalid_en(cfg_q.invalid_en),
            .bypass(bypass), .dac_bit(dac_bit[c]),
            .mute_req(mute_req[c]), .atten_req(atten_req[c])
        );
    end

    assign mute_any = |{mute_req, atten_req};
endmodule

// File: rtl/dsd_validity_monitor_chk.sv
// Property checker bound to the monitor top. Tracks its own count of
// sampled bits so the fill rule is checked without touching the RTL counters.
module dsd_validity_monitor_chk #(
    parameter int NCH = 2,
    parameter int WIN = 28
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bclk_en,
    input logic           bypass,
    input logic           static_q,
    input logic           invalid_q,
    input logic [NCH-1:0] mute_req,
    input logic [NCH-1:0] atten_req,
    input logic           mute_any
);
    localparam int CW = $clog2(WIN + 1);
    logic [CW-1:0] seen;

    // Independent count of sampled bits, saturating at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen <= '0;
        else if (bclk_en && seen != CW'(WIN))
            seen <= seen + 1'b1;
    end

    // R6
    early_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != CW'(WIN)) |-> (mute_req == '0 && atten_req == '0));
    // R8
    bypass_no_atten_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> (atten_req == '0));
    // R7
    static_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !static_q |-> (mute_req == '0));
    // R7
    invalid_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !invalid_q |-> (atten_req == '0));
    // R9
    combined_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({mute_req, atten_req}) != 0) |-> mute_any);
    // R9
    combined_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute_any |-> ($countones({mute_req, atten_req}) != 0));
endmodule

bind dsd_validity_monitor dsd_validity_monitor_chk #(.NCH(NCH), .WIN(WIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .bypass(bypass),
    .static_q(cfg_q.static_en), .invalid_q(cfg_q.invalid_en),
    .mute_req(mute_req), .atten_req(atten_req), .mute_any(mute_any)
);

// File: tb/test_dsd_validity_monitor.sv
module test_dsd_validity_monitor;
    localparam int NCH = 2;
    localparam int WIN = 28;
    localparam int THR = 24;

    logic clk = 1'b0;
    logic rst_n;
    logic bclk_en;
    logic [NCH-1:0] dsd_bit;
    logic cfg_we, cfg_static_d, cfg_invalid_d, bypass;
    logic [NCH-1:0] dac_bit, mute_req, atten_req;
    logic mute_any;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // model state
    logic [WIN-1:0] m_hist [NCH];
    int m_cnt;
    bit m_st, m_inv;

    always #2 clk = ~clk;

    dsd_validity_monitor #(.NCH(NCH), .WIN(WIN), .THRESH(THR)) i_dsd_validity_monitor (
        .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .dsd_bit(dsd_bit),
        .cfg_we(cfg_we), .cfg_static_d(cfg_static_d), .cfg_invalid_d(cfg_invalid_d),
        .bypass(bypass), .dac_bit(dac_bit), .mute_req(mute_req),
        .atten_req(atten_req), .mute_any(mute_any)
    );

    function automatic int ones_of(logic [WIN-1:0] h);
        int n = 0;
        for (int i = 0; i < WIN; i++) n += int'(h[i]);
        return n;
    endfunction

    function automatic bit exp_static(int c);
        int n = ones_of(m_hist[c]);
        return m_st && m_cnt >= WIN && (n == 0 || n == WIN);
    endfunction

    function automatic bit exp_inv(int c);
        int n = ones_of(m_hist[c]);
        return m_inv && !bypass && m_cnt >= WIN && (n > THR || WIN - n > THR);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [NCH-1:0] em, ea, ed;
        for (int c = 0; c < NCH; c++) begin
            em[c] = exp_static(c);
            ea[c] = exp_inv(c);
            ed[c] = bypass ? dsd_bit[c] : (m_cnt > 0 ? m_hist[c][0] : 1'b0);
        end
        chk("R1/R5/R7 mute_req", 32'(mute_req), 32'(em));
        chk("R3/R5/R7 atten_req", 32'(atten_req), 32'(ea));
        chk("R8 dac_bit", 32'(dac_bit), 32'(ed));
        chk("R9 mute_any", 32'(mute_any), 32'(|{em, ea}));
    endtask

    // One cycle: apply inputs, clock, update model, check at falling edge.
    task automatic step(bit en, logic [NCH-1:0] d);
        bclk_en = en;
        dsd_bit = d;
        @(posedge clk);
        if (cfg_we) begin
            m_st  = cfg_static_d;
            m_inv = cfg_invalid_d;
        end
        if (en) begin
            for (int c = 0; c < NCH; c++) m_hist[c] = {m_hist[c][WIN-2:0], d[c]};
            if (m_cnt < WIN) m_cnt++;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        check_all();
    endtask

    task automatic write_cfg(bit s, bit i);
        cfg_we = 1'b1;
        cfg_static_d = s;
        cfg_invalid_d = i;
        step(1'b0, dsd_bit);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bclk_en = 1'b0; dsd_bit = '0; cfg_we = 1'b0;
        cfg_static_d = 1'b0; cfg_invalid_d = 1'b0; bypass = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < NCH; c++) m_hist[c] = '0;
        m_cnt = 0; m_st = 1'b1; m_inv = 1'b0;
    endtask

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // R2: reset state, no requests, dac bit zero
        check_all();
        chk("R6 reset mute_req", 32'(mute_req), 0);

        // R6/R1: 27 zeros do not mute, the 28th does
        for (int i = 0; i < WIN - 1; i++) step(1'b1, 2'b00);
        chk("R6 no mute at 27 bits", 32'(mute_req), 0);
        step(1'b1, 2'b00);
        chk("R1 mute at 28 bits, R2 static default on", 32'(mute_req), 32'b11);
        chk("R2 invalid default off", 32'(atten_req), 0);
        // R4: no enable, nothing moves
        step(1'b0, 2'b11);
        chk("R4 hold without enable", 32'(mute_req), 32'b11);
        // R5: a differing bit on channel 0 clears it at once
        step(1'b1, 2'b01);
        chk("R5 clear on change", 32'(mute_req), 32'b10);

        // R10/R3: enable invalid, build 25/28 ones on ch0, 24/28 on ch1
        write_cfg(1'b1, 1'b1);
        for (int i = 0; i < WIN; i++)
            step(1'b1, {1'(i >= 4), 1'(i >= 3)});
        chk("R3 25 ones attenuate, 24 ones not", 32'(atten_req), 32'b01);
        // R8: bypass suppresses attenuation and passes data through
        bypass = 1'b1;
        step(1'b0, 2'b10);
        chk("R8 bypass atten off", 32'(atten_req), 0);
        chk("R8 bypass passthrough", 32'(dac_bit), 32'b10);
        bypass = 1'b0;
        step(1'b0, 2'b00);
        // R7: disable both detectors with full ones stream
        for (int i = 0; i < WIN; i++) step(1'b1, 2'b11);
        chk("R1 all-ones mute", 32'(mute_req), 32'b11);
        write_cfg(1'b0, 1'b0);
        chk("R7 static disabled", 32'(mute_req), 0);
        chk("R7 invalid disabled", 32'(atten_req), 0);
        write_cfg(1'b1, 1'b1);

        // Random phase with bias that varies per segment
        for (int seg = 0; seg < 60; seg++) begin
            int p = $urandom_range(0, 100);
            bit byp = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 7) == 0)
                write_cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            bypass = byp;
            for (int k = 0; k < 60; k++) begin
                logic [NCH-1:0] d;
                for (int c = 0; c < NCH; c++) d[c] = ($urandom_range(0, 99) < p);
                step(($urandom_range(0, 3) != 0), d);
            end
        end
        bypass = 1'b0;

        // R6 again after a fresh reset
        do_reset();
        for (int i = 0; i < WIN - 1; i++) step(1'b1, 2'b11);
        chk("R6 no detection before fill after reset", 32'(mute_any), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule